// File: doc/BRIEF.md
# Write-Protect Gate for a Serial Nonvolatile Memory

This block holds the protection state of a 1K x 8 serial nonvolatile memory and decides, in the same cycle, whether each decoded write command may proceed. A command decoder upstream supplies single-cycle strobes for the following:

- write-enable set;
- write-enable reset;
- status write, with its data byte;
- array write, with a 16-bit address.

The external write-protect pin is also an input; it is active low.

The block answers each status write and each array write with a grant flag. The state it holds consists of:

- a volatile write-enable latch;
- a two-bit region code that protects a quarter, a half or all of the array, counted from the top of memory;
- a lock-enable bit that lets the pin freeze the status register.

A status byte exposes this state for read-back. Serial shifting and the storage array sit outside this block.

Grants are combinational from the strobes and the current state. State changes take effect at the next rising clock edge.

Top module: `wp_guard`

## Requirements
- R1: With region code 00, no array address is protected: an array write with the latch set is granted at every address.
- R2: With region code 01, addresses 0x300 to 0x3FF are refused and addresses 0x000 to 0x2FF are granted.
- R3: With region code 10, addresses 0x200 to 0x3FF are refused and addresses 0x000 to 0x1FF are granted.
- R4: With region code 11, every array address is refused.
- R5: Address bits 15:10 take no part in the region decision. Only bits 9:0 are compared.
- R6: Hardware lock is active exactly when the pin is low and the lock-enable bit is 1. While it is active, every status write is refused and the region code and lock-enable bit keep their values. This means lock-enable cannot be cleared while the pin stays low.
- R7: A status write with the latch set and no hardware lock is granted. At the next edge it loads the region code from data bits 3:2 and lock-enable from data bit 7.
- R8: While the write-enable latch is 0, every status write and every array write is refused.
- R9: The write-enable latch is set by the set strobe. It is cleared by the reset strobe and by any granted write. A clear takes priority over a set in the same cycle.
- R10: The status byte has lock-enable in bit 7, the region code in bits 3:2 and the latch in bit 1. Bits 6:4 and bit 0 (busy) read 0.
- R11: On reset the latch is 0. The region code and lock-enable take the values of the parameters `INIT_REGION` and `INIT_LOCK_EN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wren_set_i | input | 1 | Write-enable set strobe |
| wren_clr_i | input | 1 | Write-enable reset strobe |
| sts_wr_i | input | 1 | Status write strobe |
| sts_data_i | input | 8 | Data byte for a status write |
| arr_wr_i | input | 1 | Array write strobe |
| arr_addr_i | input | ADDR_W (16) | Byte address of the array write |
| wp_n_i | input | 1 | External write-protect pin, low = protect |
| sts_ok_o | output | 1 | Grant for the status write in this cycle |
| arr_ok_o | output | 1 | Grant for the array write in this cycle |
| status_o | output | 8 | Status byte for read-back |

## Verification
The bench builds the block with `INIT_REGION` = 10 and `INIT_LOCK_EN` = 1, so the state right after reset differs from the default all-zero state. It also starts with hardware lock reachable as soon as the pin goes low. The address width stays at 16 with 10 significant bits. Random addresses therefore carry nonzero upper bits, which exercises the rule that those bits are ignored, alongside the 0x1FF/0x200 and 0x2FF/0x300 boundaries. Random data bytes set and clear lock-enable while the pin toggles, so all four region codes are visited both with and without hardware lock.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

   localparam int STS_W        = 8;
   localparam int STS_LOCK_BIT = 7;
   localparam int STS_RGN_LO   = 2;
   localparam int STS_WEL_BIT  = 1;
   localparam int STS_BUSY_BIT = 0;
   localparam int NUM_SEG      = 4;

   typedef enum logic [1:0] {
      RGN_NONE    = 2'b00,
      RGN_QUARTER = 2'b01,
      RGN_HALF    = 2'b10,
      RGN_ALL     = 2'b11
   } region_e;

   typedef struct packed {
      logic    lock_en;
      region_e region;
   } nv_state_t;

   function automatic logic [STS_W-1:0] pack_status(nv_state_t st, logic wel);
      logic [STS_W-1:0] b;
      b = '0;
      b[STS_LOCK_BIT]               = st.lock_en;
      b[STS_RGN_LO+1 : STS_RGN_LO]  = st.region;
      b[STS_WEL_BIT]                = wel;
      b[STS_BUSY_BIT]               = 1'b0;
      return b;
   endfunction

endpackage

// File: rtl/wpg_region.sv
module wpg_region
   import wpg_pkg::*;
#(
   parameter int SIG_W = 10
)(
   input  region_e          region,
   input  logic [SIG_W-1:0] addr,
   output logic             hit
);

   localparam int SEG_BITS = 2;

   logic [SEG_BITS-1:0] seg;
   logic [NUM_SEG-1:0]  seg_prot;

   generate
      if (SIG_W < SEG_BITS) begin : g_bad_sig_w
         $error("wpg_region: SIG_W must be at least 2");
      end
   endgenerate

   assign seg = addr[SIG_W-1 -: SEG_BITS];

   // Segment q is protected when the region code reaches down to it from the top.
   generate
      for (genvar q = 0; q < NUM_SEG; q++) begin : g_seg
         always_comb begin
            unique case (region)
               RGN_NONE:    seg_prot[q] = 1'b0;
               RGN_QUARTER: seg_prot[q] = (q == NUM_SEG - 1);
               RGN_HALF:    seg_prot[q] = (q >= NUM_SEG / 2);
               default:     seg_prot[q] = 1'b1;
            endcase
         end
      end
   endgenerate

   assign hit = seg_prot[seg];

   always_comb begin
      if (region == RGN_NONE) begin
         p_none_protects_nothing_r1: assert (hit == 1'b0);
      end
      if (region == RGN_ALL) begin
         p_all_protects_everything_r4: assert (hit == 1'b1);
      end
   end

endmodule

// File: rtl/wpg_wel.sv
module wpg_wel (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic done_i,
   output logic wel_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_o <= 1'b0;
      end else if (clr_i || done_i) begin
         wel_o <= 1'b0;
      end else if (set_i) begin
         wel_o <= 1'b1;
      end
   end

   p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i || done_i) |=> !wel_o);

   p_set_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i && !done_i) |=> wel_o);

endmodule

// File: rtl/wpg_nvreg.sv
module wpg_nvreg
   import wpg_pkg::*;
#(
   parameter logic [1:0] INIT_REGION  = 2'b00,
   parameter logic       INIT_LOCK_EN = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [STS_W-1:0] data_i,
   input  logic             wp_n_i,
   output nv_state_t        state_o,
   output logic             hw_lock_o
);

   nv_state_t init_st;
   assign init_st.lock_en = INIT_LOCK_EN;
   assign init_st.region  = region_e'(INIT_REGION);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= init_st;
      end else if (wr_i) begin
         state_o.lock_en <= data_i[STS_LOCK_BIT];
         state_o.region  <= region_e'(data_i[STS_RGN_LO+1 : STS_RGN_LO]);
      end
   end

   assign hw_lock_o = !wp_n_i && state_o.lock_en;

   p_locked_bits_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n_i && state_o.lock_en) |=> $stable(state_o));

   p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (state_o.region == $past(data_i[STS_RGN_LO+1 : STS_RGN_LO])
                && state_o.lock_en == $past(data_i[STS_LOCK_BIT])));

endmodule

// File: rtl/wp_guard.sv
module wp_guard
   import wpg_pkg::*;
#(
   parameter int         ADDR_W       = 16,
   parameter int         SIG_W        = 10,
   parameter logic [1:0] INIT_REGION  = 2'b00,
   parameter logic       INIT_LOCK_EN = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wren_set_i,
   input  logic              wren_clr_i,
   input  logic              sts_wr_i,
   input  logic [7:0]        sts_data_i,
   input  logic              arr_wr_i,
   input  logic [ADDR_W-1:0] arr_addr_i,
   input  logic              wp_n_i,
   output logic              sts_ok_o,
   output logic              arr_ok_o,
   output logic [7:0]        status_o
);

   generate
      if (SIG_W > ADDR_W) begin : g_bad_width
         $error("wp_guard: SIG_W must not exceed ADDR_W");
      end
   endgenerate

   nv_state_t nv;
   logic      hw_lock;
   logic      wel;
   logic      region_hit;

   wpg_region #(.SIG_W(SIG_W)) u_region (
      .region (nv.region),
      .addr   (arr_addr_i[SIG_W-1:0]),
      .hit    (region_hit)
   );

   assign sts_ok_o = sts_wr_i && wel && !hw_lock;
   assign arr_ok_o = arr_wr_i && wel && !region_hit;

   wpg_nvreg #(
      .INIT_REGION  (INIT_REGION),
      .INIT_LOCK_EN (INIT_LOCK_EN)
   ) u_nvreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (sts_ok_o),
      .data_i    (sts_data_i),
      .wp_n_i    (wp_n_i),
      .state_o   (nv),
      .hw_lock_o (hw_lock)
   );

   wpg_wel u_wel (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (wren_set_i),
      .clr_i  (wren_clr_i),
      .done_i (sts_ok_o || arr_ok_o),
      .wel_o  (wel)
   );

   assign status_o = pack_status(nv, wel);

   p_no_latch_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[STS_WEL_BIT] |-> (!sts_ok_o && !arr_ok_o));

   p_pin_lock_refuses_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n_i && status_o[STS_LOCK_BIT]) |-> !sts_ok_o);

   p_fixed_bits_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[6:4] == 3'b000) && !status_o[STS_BUSY_BIT]);

endmodule

// File: tb/tb_wp_guard.sv
module tb_wp_guard;

   localparam int         CLK_PERIOD = 10;
   localparam logic [1:0] T_REGION   = 2'b10;
   localparam logic       T_LOCK     = 1'b1;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wren_set_i, wren_clr_i, sts_wr_i, arr_wr_i, wp_n_i;
   logic [7:0]  sts_data_i;
   logic [15:0] arr_addr_i;
   logic        sts_ok_o, arr_ok_o;
   logic [7:0]  status_o;

   int n_vec  = 0;
   int n_fail = 0;
   bit m_wel;
   bit m_en;
   bit [1:0] m_rgn;

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_guard #(.ADDR_W(16), .SIG_W(10), .INIT_REGION(T_REGION), .INIT_LOCK_EN(T_LOCK)) dut (
      .clk(clk), .rst_n(rst_n), .wren_set_i(wren_set_i), .wren_clr_i(wren_clr_i),
      .sts_wr_i(sts_wr_i), .sts_data_i(sts_data_i), .arr_wr_i(arr_wr_i),
      .arr_addr_i(arr_addr_i), .wp_n_i(wp_n_i), .sts_ok_o(sts_ok_o),
      .arr_ok_o(arr_ok_o), .status_o(status_o)
   );

   function automatic bit prot(bit [1:0] rgn, logic [15:0] a);
      case (rgn)
         2'b00:   return 1'b0;
         2'b01:   return a[9:0] >= 10'h300;
         2'b10:   return a[9:0] >= 10'h200;
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [7:0] exp_status(bit en, bit [1:0] rgn, bit wel);
      return {en, 3'b000, rgn, wel, 1'b0};
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit s, input bit c, input bit sw, input logic [7:0] d,
                       input bit aw, input logic [15:0] a, input bit pin);
      bit es, ea, nwel;
      string ts, ta;
      @(negedge clk);
      wren_set_i = s; wren_clr_i = c; sts_wr_i = sw; sts_data_i = d;
      arr_wr_i = aw; arr_addr_i = a; wp_n_i = pin;
      #1;
      es = sw && m_wel && !(!pin && m_en);
      ea = aw && m_wel && !prot(m_rgn, a);
      ts = !m_wel ? "R8" : (!pin && m_en) ? "R6" : "R7";
      if (!m_wel)               ta = "R8";
      else if (a[15:10] != 0)   ta = "R5";
      else case (m_rgn)
         2'b00: ta = "R1";
         2'b01: ta = "R2";
         2'b10: ta = "R3";
         default: ta = "R4";
      endcase
      chk({7'd0, sts_ok_o}, {7'd0, es}, ts, "status grant");
      chk({7'd0, arr_ok_o}, {7'd0, ea}, ta, "array grant");
      chk({7'd0, status_o[1]}, {7'd0, m_wel}, "R9", "latch bit");
      chk(status_o, exp_status(m_en, m_rgn, m_wel), "R10", "status byte");
      nwel = (c || es || ea) ? 1'b0 : (s ? 1'b1 : m_wel);
      @(posedge clk);
      if (es) begin
         m_en  = d[7];
         m_rgn = d[3:2];
      end
      m_wel = nwel;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      rst_n = 1'b0;
      wren_set_i = 0; wren_clr_i = 0; sts_wr_i = 0; sts_data_i = 0;
      arr_wr_i = 0; arr_addr_i = 0; wp_n_i = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: state after reset
      chk(status_o, exp_status(T_LOCK, T_REGION, 1'b0), "R11", "reset status");
      chk({6'd0, sts_ok_o, arr_ok_o}, 8'd0, "R11", "reset grants");
      rst_n = 1'b1;
      m_wel = 0; m_en = T_LOCK; m_rgn = T_REGION;

      // Directed corners
      step(0,0,0,8'h00,1,16'h0000,1);          // R8 refused without latch
      step(1,0,0,8'h00,0,16'h0000,1);
      step(0,0,1,8'h04,0,16'h0000,1);          // R7 load region 01
      step(1,0,0,8'h00,0,16'h0000,1);
      step(0,0,0,8'h00,1,16'hFD00,1);          // R5 upper bits ignored, 0x100 granted
      step(1,0,0,8'h00,0,16'h0000,1);
      step(0,0,0,8'h00,1,16'h07FF,1);          // R5/R2 0x3FF refused
      step(1,0,0,8'h00,0,16'h0000,1);
      step(0,0,0,8'h00,1,16'h02FF,1);          // R2 boundary granted
      step(1,0,0,8'h00,0,16'h0000,1);
      step(0,0,1,8'h8C,0,16'h0000,1);          // R7 lock on, region 11
      step(1,0,0,8'h00,0,16'h0000,1);
      step(0,0,0,8'h00,1,16'h0000,1);          // R4 refused
      step(0,0,1,8'h00,0,16'h0000,0);          // R6 pin low: refused, bits held
      step(0,0,1,8'h00,0,16'h0000,0);          // R6 still held
      step(1,1,0,8'h00,0,16'h0000,1);          // R9 clear wins over set
      step(0,0,1,8'h00,0,16'h0000,1);          // R8 no latch
      step(1,0,0,8'h00,0,16'h0000,1);
      step(0,0,1,8'h08,0,16'h0000,1);          // R7 pin high: region 10, lock off
      step(1,0,0,8'h00,0,16'h0000,0);
      step(0,0,0,8'h00,1,16'h01FF,0);          // R3 boundary granted
      step(1,0,0,8'h00,0,16'h0000,0);
      step(0,0,0,8'h00,1,16'h0200,0);          // R3 boundary refused
      step(1,0,0,8'h00,0,16'h0000,0);
      step(0,0,1,8'h00,0,16'h0000,0);          // R6 inactive with lock 0: region 00
      step(1,0,0,8'h00,0,16'h0000,0);
      step(0,0,0,8'h00,1,16'hFFFF,0);          // R1 top address granted

      // Constrained random
      for (int i = 0; i < 4000; i++) begin
         int k;
         bit s, c, sw, aw;
         logic [7:0]  d;
         logic [15:0] a;
         k  = $urandom_range(0, 99);
         s  = (k < 40);
         c  = (k >= 40 && k < 47);
         sw = (k >= 47 && k < 65);
         aw = (k >= 65);
         d  = 8'($urandom);
         a  = 16'($urandom);
         if ($urandom_range(0, 3) == 0) a[9:0] = ($urandom_range(0, 1) != 0) ? 10'h2FF : 10'h300;
         step(s, c, sw, d, aw, a, 1'($urandom_range(0, 1)));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule